// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block turns compare events of a free-running 16-bit timer into actions on eight timer port pins. Each channel holds a compare value. On a counter increment where the counter equals that value, the channel's 2-bit pin action is applied to its own pin and the channel's match flag is raised. Software can trigger the same pin action at any time by writing a 1 to the channel's bit in a force register. A forced event applies the pin action but leaves the flag alone.

Channel 7 has an additional mask/data pair that reaches across the whole port. When channel 7 fires, each pin whose mask bit is set takes the matching data bit. A set mask bit also takes that pin away from its own channel's pin action. While channel 7 is in output-compare mode, a set mask bit turns the pin into an output whatever its direction bit says.

The counter, input capture, the prescaler and interrupt routing sit outside the block.

Top module: `oc_pin_unit`

## Requirements
- R1: A channel whose mode bit is 1 (output compare) has a real match when `cntInc` is 1 and `cntVal` equals its compare value. On the next clock edge its flag in `matchFlag` becomes 1 and its pin action is applied. If `cntInc` is 0, equality does nothing.
- R2: The pin action of channel n sits in `pinAct[2n+1:2n]`. 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R3: Writing with `regAddr`=0 (force register) applies, at the next edge, the pin action of every output-compare channel whose data bit is 1. The flag of that channel does not change.
- R4: If a force and a real match hit the same channel in the same cycle, its pin action is applied once (a toggle flips the pin once) and its flag is set.
- R5: Flags stay set until a 1 is written to the corresponding bit of `flagClr`. If a real match and a clear land in the same cycle, the flag stays set.
- R6: `regRdData` returns 0x00 for address 0. For address 1 it returns the mask register and for address 2 the data register, each as last written with `regWrEn`.
- R7: When channel 7 fires, whether by real match or by force, every pin with a mask bit of 1 is loaded with the matching data bit at the same edge. Pins with a mask bit of 0 are not touched by it.
- R8: While mask bit n is 1, channel n's own pin action has no effect on pin n.
- R9: `portOe[n]` is 1 if `dirBits[n]` is 1, or if mask bit n is 1 and channel 7 is in output-compare mode, or if channel n is in output-compare mode with a nonzero pin action and mask bit n is 0.
- R10: Channels whose mode bit is 0 ignore both matches and forces.
- R11: After reset, `portOut`, `matchFlag`, the mask register and the data register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntVal | input | 16 | Current timer counter value |
| cntInc | input | 1 | Counter advances this cycle |
| cmpVal | input | 128 | Compare values, channel n at bits [16n+15:16n] |
| ocMode | input | 8 | Per-channel mode, 1 = output compare |
| pinAct | input | 16 | Per-channel 2-bit pin action codes |
| dirBits | input | 8 | Port direction bits, 1 = output |
| flagClr | input | 8 | Write-1-to-clear strobes for match flags |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 force, 1 mask, 2 data |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| portOut | output | 8 | Timer port pin values |
| portOe | output | 8 | Timer port output enables |
| matchFlag | output | 8 | Per-channel match flags |

## Verification
The assertions assume that `flagClr` never clears a flag in the cycle right after a forced-only event. They also assume that the pin action and mask bits stay constant across the edge on which an event is registered. The bench satisfies both assumptions by driving every input on the falling edge and holding it for a full cycle. It changes pin actions, masks and modes only in cycles without events. It pulses `flagClr` only in cycles it has set aside for clearing.

// File: rtl/ocPkg.sv
package ocPkg;
  localparam int OC_CH = 8;
  localparam int CH7 = OC_CH - 1;
  localparam int ACT_W = 2;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_FORCE = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_MASK  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_DATA  = 2'd2;
  localparam logic [ACT_W-1:0] ACT_NONE = 2'b00;
  localparam logic [ACT_W-1:0] ACT_TOG  = 2'b01;
  localparam logic [ACT_W-1:0] ACT_LOW  = 2'b10;
  localparam logic [ACT_W-1:0] ACT_HIGH = 2'b11;

  typedef struct packed {
    logic [OC_CH-1:0] hit;   // real compare match
    logic [OC_CH-1:0] fire;  // apply pin action (match or force)
  } ocStrobe_t;
endpackage

// File: rtl/ocCtrl.sv
module ocCtrl
  import ocPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CNT_W-1:0]         cntVal,
  input  logic                     cntInc,
  input  logic [OC_CH*CNT_W-1:0]   cmpVal,
  input  logic [OC_CH-1:0]         ocMode,
  input  logic                     regWrEn,
  input  logic [REG_AW-1:0]        regAddr,
  input  logic [OC_CH-1:0]         regWrData,
  output logic [OC_CH-1:0]         regRdData,
  output logic [OC_CH-1:0]         mask7,
  output logic [OC_CH-1:0]         data7,
  output ocStrobe_t                stb
);
  logic [OC_CH-1:0] forceBits;
  logic [OC_CH-1:0] hitVec;

  for (genvar n = 0; n < OC_CH; n++) begin : g_cmp
    assign hitVec[n] = cntInc && ocMode[n] && (cntVal == cmpVal[n*CNT_W +: CNT_W]);
  end

  assign forceBits = (regWrEn && regAddr == ADDR_FORCE) ? regWrData : '0;
  assign stb.hit  = hitVec;
  assign stb.fire = hitVec | (forceBits & ocMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask7 <= '0;
      data7 <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_MASK) mask7 <= regWrData;
      if (regAddr == ADDR_DATA) data7 <= regWrData;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_MASK: regRdData = mask7;
      ADDR_DATA: regRdData = data7;
      default:   regRdData = '0;
    endcase
  end

  // Mask register keeps its value across cycles without a mask write
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_MASK) |=> $stable(mask7));
  // Events are only produced for output-compare channels
  assert_mode_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire & ~ocMode) == '0);
endmodule

// File: rtl/ocDatapath.sv
module ocDatapath
  import ocPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ocStrobe_t                stb,
  input  logic [OC_CH*ACT_W-1:0]   pinAct,
  input  logic [OC_CH-1:0]         mask7,
  input  logic [OC_CH-1:0]         data7,
  input  logic [OC_CH-1:0]         dirBits,
  input  logic [OC_CH-1:0]         ocMode,
  input  logic [OC_CH-1:0]         flagClr,
  output logic [OC_CH-1:0]         portOut,
  output logic [OC_CH-1:0]         portOe,
  output logic [OC_CH-1:0]         matchFlag
);
  logic [OC_CH-1:0] nextPort;

  for (genvar n = 0; n < OC_CH; n++) begin : g_pin
    logic [ACT_W-1:0] act;
    assign act = pinAct[n*ACT_W +: ACT_W];

    always_comb begin
      nextPort[n] = portOut[n];
      if (stb.fire[n] && !mask7[n]) begin
        case (act)
          ACT_TOG:  nextPort[n] = ~portOut[n];
          ACT_LOW:  nextPort[n] = 1'b0;
          ACT_HIGH: nextPort[n] = 1'b1;
          default:  nextPort[n] = portOut[n];
        endcase
      end
      if (stb.fire[CH7] && mask7[n]) nextPort[n] = data7[n];
    end

    assign portOe[n] = dirBits[n]
                     | (mask7[n] & ocMode[CH7])
                     | (ocMode[n] & (act != ACT_NONE) & ~mask7[n]);

    // Pin holds when neither its channel nor a masked channel-7 event fires
    assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.fire[n] && !mask7[n]) && !(stb.fire[CH7] && mask7[n]) |=> $stable(portOut[n]));
    // Toggle flips the pin exactly once
    assert_toggle_once_R4: assert property (@(posedge clk) disable iff (!rstN)
      stb.fire[n] && !mask7[n] && act == ACT_TOG |=> portOut[n] != $past(portOut[n]));
    // Channel-7 mask transfer wins
    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rstN)
      stb.fire[CH7] && mask7[n] |=> portOut[n] == $past(data7[n]));
    // Real match raises the flag
    assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rstN)
      stb.hit[n] |=> matchFlag[n]);
    // Force alone never raises a flag
    assert_force_no_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
      stb.fire[n] && !stb.hit[n] && !matchFlag[n] |=> !matchFlag[n]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portOut   <= '0;
      matchFlag <= '0;
    end else begin
      portOut   <= nextPort;
      matchFlag <= (matchFlag & ~flagClr) | stb.hit;
    end
  end
endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
  import ocPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CNT_W-1:0]       cntVal,
  input  logic                   cntInc,
  input  logic [OC_CH*CNT_W-1:0] cmpVal,
  input  logic [OC_CH-1:0]       ocMode,
  input  logic [OC_CH*ACT_W-1:0] pinAct,
  input  logic [OC_CH-1:0]       dirBits,
  input  logic [OC_CH-1:0]       flagClr,
  input  logic                   regWrEn,
  input  logic [REG_AW-1:0]      regAddr,
  input  logic [OC_CH-1:0]       regWrData,
  output logic [OC_CH-1:0]       regRdData,
  output logic [OC_CH-1:0]       portOut,
  output logic [OC_CH-1:0]       portOe,
  output logic [OC_CH-1:0]       matchFlag
);
  ocStrobe_t stb;
  logic [OC_CH-1:0] mask7;
  logic [OC_CH-1:0] data7;

  ocCtrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntInc(cntInc), .cmpVal(cmpVal),
    .ocMode(ocMode), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .mask7(mask7), .data7(data7), .stb(stb)
  );

  ocDatapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pinAct(pinAct), .mask7(mask7),
    .data7(data7), .dirBits(dirBits), .ocMode(ocMode), .flagClr(flagClr),
    .portOut(portOut), .portOe(portOe), .matchFlag(matchFlag)
  );
endmodule

// File: tb/test_oc_pin_unit.sv
module test_oc_pin_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cntVal = '0;
  logic cntInc = 1'b0;
  logic [127:0] cmpVal;
  logic [15:0] cmpArr [8];
  logic [7:0] ocMode = '0;
  logic [15:0] pinAct = '0;
  logic [7:0] dirBits = '0;
  logic [7:0] flagClr = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData, portOut, portOe, matchFlag;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) cmpVal[i*16 +: 16] = cmpArr[i];

  oc_pin_unit i_oc_pin_unit (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntInc(cntInc), .cmpVal(cmpVal),
    .ocMode(ocMode), .pinAct(pinAct), .dirBits(dirBits), .flagClr(flagClr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .portOut(portOut), .portOe(portOe), .matchFlag(matchFlag)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setAct(int ch, logic [1:0] code);
    pinAct[ch*2 +: 2] = code;
  endtask

  // one-cycle pulse: inputs set at negedge, held through posedge, released at next negedge
  task automatic pulse(logic inc, logic [7:0] clr, logic wr, logic [1:0] addr, logic [7:0] wd);
    @(negedge clk);
    cntInc = inc; flagClr = clr; regWrEn = wr; regAddr = addr; regWrData = wd;
    @(negedge clk);
    cntInc = 0; flagClr = '0; regWrEn = 0; regWrData = '0;
  endtask

  task automatic t_reset;
    check("R11 port", portOut, 8'h00);
    check("R11 flags", matchFlag, 8'h00);
    regAddr = 2'd1; #1; check("R11 mask", regRdData, 8'h00);
    regAddr = 2'd2; #1; check("R11 data", regRdData, 8'h00);
    regAddr = 2'd0;
  endtask

  task automatic t_match;
    ocMode = 8'hFF; setAct(0, 2'b11); setAct(1, 2'b01);
    cmpArr[0] = 16'h0100; cmpArr[1] = 16'h0100; cntVal = 16'h0100;
    pulse(0, 0, 0, 0, 0);
    check("R1 no inc port", portOut, 8'h00);
    check("R1 no inc flag", matchFlag, 8'h00);
    pulse(1, 0, 0, 0, 0);
    check("R1 R2 match port", portOut, 8'h03);
    check("R1 match flags", matchFlag, 8'h03);
  endtask

  task automatic t_clear;
    pulse(0, 8'h01, 0, 0, 0);
    check("R5 clear", matchFlag, 8'h02);
    cmpArr[0] = 16'hFFFF;
    pulse(1, 8'h02, 0, 0, 0);
    check("R5 set wins", matchFlag, 8'h02);
    check("R2 toggle back", portOut, 8'h01);
    pulse(0, 8'h02, 0, 0, 0);
    check("R5 clear2", matchFlag, 8'h00);
  endtask

  task automatic t_force;
    setAct(3, 2'b11);
    pulse(0, 0, 1, 2'd0, 8'h08);
    check("R3 force high", portOut, 8'h09);
    check("R3 no flag", matchFlag, 8'h00);
    pulse(0, 0, 1, 2'd0, 8'h02);
    check("R3 force toggle", portOut, 8'h0B);
    check("R3 no flag2", matchFlag, 8'h00);
    setAct(3, 2'b10);
    pulse(0, 0, 1, 2'd0, 8'h08);
    check("R2 drive low", portOut, 8'h03);
    setAct(3, 2'b11);
    pulse(0, 0, 1, 2'd0, 8'h08);
    check("R2 drive high", portOut, 8'h0B);
  endtask

  task automatic t_both;
    pulse(1, 0, 1, 2'd0, 8'h02);
    check("R4 single toggle", portOut, 8'h09);
    check("R4 flag", matchFlag, 8'h02);
    pulse(0, 8'hFF, 0, 0, 0);
    cmpArr[1] = 16'hFFFF;
  endtask

  task automatic t_regs;
    pulse(0, 0, 1, 2'd1, 8'hF0);
    pulse(0, 0, 1, 2'd2, 8'hA0);
    regAddr = 2'd1; #1; check("R6 mask rd", regRdData, 8'hF0);
    regAddr = 2'd2; #1; check("R6 data rd", regRdData, 8'hA0);
    regAddr = 2'd0; #1; check("R6 force rd", regRdData, 8'h00);
    check("R7 no event port", portOut, 8'h09);
  endtask

  task automatic t_oe;
    check("R9 oe mask", portOe, 8'hFB);
    dirBits = 8'h04; #1;
    check("R9 oe dir", portOe, 8'hFF);
    ocMode = 8'h00; #1;
    check("R9 oe dir only", portOe, 8'h04);
    ocMode = 8'h80; dirBits = 8'h00; #1;
    check("R9 oe ch7 only", portOe, 8'hF0);
    ocMode = 8'hFF; #1;
  endtask

  task automatic t_ch7;
    setAct(7, 2'b11); setAct(6, 2'b10);
    pulse(0, 0, 1, 2'd0, 8'h80);
    check("R7 forced ch7", portOut, 8'hA9);
    check("R3 ch7 no flag", matchFlag, 8'h00);
    pulse(0, 0, 1, 2'd2, 8'h50);
    cmpArr[7] = 16'h0100;
    pulse(1, 0, 0, 0, 0);
    check("R7 real ch7", portOut, 8'h59);
    check("R1 ch7 flag", matchFlag, 8'h80);
    cmpArr[7] = 16'hFFFF;
    pulse(0, 0, 1, 2'd0, 8'h40);
    check("R8 masked ch6", portOut, 8'h59);
  endtask

  task automatic t_mode;
    pulse(0, 8'hFF, 1, 2'd1, 8'h00);
    setAct(2, 2'b11); ocMode = 8'hFB; cmpArr[2] = 16'h0100;
    pulse(0, 0, 1, 2'd0, 8'h04);
    check("R10 force ignored", portOut, 8'h59);
    pulse(1, 0, 0, 0, 0);
    check("R10 match ignored", matchFlag, 8'h00);
    check("R10 port kept", portOut, 8'h59);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) cmpArr[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_clear();
    t_force();
    t_both();
    t_regs();
    t_oe();
    t_ch7();
    t_mode();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule